// File: doc/BRIEF.md
# Latched Parity Bus Transceiver

This block connects two 8-bit buses, side A and side B, each carrying one parity bit beside its data. Data flows in both directions at once. Each direction has its own holding stage, which is a clocked stand-in for a transparent latch. While its enable is high, the stage passes its input straight to the opposite side in the same cycle. The stage also records the input on every clock edge. When the enable is low, the stage presents the last recorded word.

The outgoing parity bit is either passed through from the received word (pass mode) or newly computed from the held data (generate mode). One input picks even or odd parity for the whole block. Each side checks its received 9-bit word without delay and reports the result on its own active-low error flag. Because of this, checking does not depend on which direction is driving or on the state of the holding stages.

Bidirectional pads are modelled as separate input, output and drive-enable ports. An output port carries zero whenever its drive enable is low. The two buses must not drive at the same time, and side A has priority when both are requested.

Top module: `parity_xcvr`

## Requirements
- R1: With `le_ab` high, `b_data_o` equals `a_data_i` in the same cycle whenever side B is driven.
- R2: With `le_ba` high, `a_data_o` equals `b_data_i` in the same cycle whenever side A is driven.
- R3: With a direction's enable low, its output shows the data and parity captured at the last rising clock edge at which the enable was high. Changes on the input bus in the meantime have no effect on that output.
- R4: In generate mode (`pass_mode` = 0), the outgoing parity bit makes the 9-bit output word hold an even number of ones when `odd_sel` = 0, and an odd number of ones when `odd_sel` = 1.
- R5: In pass mode (`pass_mode` = 1), the outgoing parity bit equals the held incoming parity bit of that direction.
- R6: `a_err_n` is high exactly when the 9-bit word {`a_data_i`, `a_par_i`} has even ones (`odd_sel` = 0) or odd ones (`odd_sel` = 1). It follows the inputs combinationally, whatever the enables are.
- R7: `b_err_n` obeys the same rule for {`b_data_i`, `b_par_i`}.
- R8: The drive requests are active low. `a_oe_o` = 1 only when `a_drv_n` = 0. `b_oe_o` = 1 only when `b_drv_n` = 0. An undriven side's data and parity outputs are zero.
- R9: When `a_drv_n` and `b_drv_n` are both low, only side A is driven: `a_oe_o` = 1 and `b_oe_o` = 0.
- R10: A synchronous reset (`rst_n` low at a rising edge) clears both holding stages to all zeros: data zero, parity zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_data_i | input | 8 | Data received from side A |
| a_par_i | input | 1 | Parity received from side A |
| b_data_i | input | 8 | Data received from side B |
| b_par_i | input | 1 | Parity received from side B |
| le_ab | input | 1 | A-to-B stage enable, high = transparent |
| le_ba | input | 1 | B-to-A stage enable, high = transparent |
| odd_sel | input | 1 | 0 = even parity, 1 = odd parity |
| pass_mode | input | 1 | 0 = generate parity, 1 = pass parity through |
| a_drv_n | input | 1 | Request to drive side A, active low |
| b_drv_n | input | 1 | Request to drive side B, active low |
| a_data_o | output | 8 | Data driven onto side A |
| a_par_o | output | 1 | Parity driven onto side A |
| a_oe_o | output | 1 | Side A pad drive enable |
| b_data_o | output | 8 | Data driven onto side B |
| b_par_o | output | 1 | Parity driven onto side B |
| b_oe_o | output | 1 | Side B pad drive enable |
| a_err_n | output | 1 | Side A parity error, active low |
| b_err_n | output | 1 | Side B parity error, active low |

## Verification
The bench closes an enable and then changes the input bus. A design that still followed the input would show the new word, not the captured one. It checks the error flags while both stages are holding, which catches flags wrongly computed from held data. It asserts both drive requests together; without side A's priority, both pads would drive. It also toggles the parity sense after reset. A generator with the sense inverted, or a pass mode that regenerates parity, would produce wrong parity bits on all-zero and mismatched words.

// File: rtl/parity_xcvr_pkg.sv
// Shared definitions for the latched parity transceiver.
// Assumes: nothing beyond IEEE 1800-2017.
package parity_xcvr_pkg;

    // Source of the outgoing parity bit
    typedef enum logic {
        PAR_GENERATE = 1'b0,
        PAR_PASS     = 1'b1
    } par_mode_e;

    // Number of traffic directions through the block
    localparam int unsigned NUM_DIR = 2;

endpackage

// File: rtl/pxc_xor_tree.sv
// Odd-ones detector: result is 1 when the input vector holds an odd number of ones.
// Assumes: W >= 1. Built as a ripple of XOR stages; synthesis rebalances it.
module pxc_xor_tree #(
    parameter int unsigned W = 9
) (
    input  logic [W-1:0] vec_i,
    output logic         odd_o
);

    logic [W-1:0] chain;

    // First stage seeds the chain
    assign chain[0] = vec_i[0];

    // Each further stage folds in one more bit
    for (genvar i = 1; i < W; i++) begin : g_stage
        assign chain[i] = chain[i-1] ^ vec_i[i];
    end

    assign odd_o = chain[W-1];

endmodule

// File: rtl/pxc_hold.sv
// Clocked stand-in for a transparent latch.
// While le_i is high the input passes straight to the output and is recorded on each edge.
// While le_i is low the last recorded value is shown.
// Assumes: the input is stable over the rising edge before le_i falls.
module pxc_hold #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] held_q;

    // Record the input while transparent; synchronous clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (le_i) begin
            held_q <= d_i;
        end
    end

    // Transparent path or held value
    assign q_o = le_i ? d_i : held_q;

endmodule

// File: rtl/pxc_lane.sv
// One direction of the transceiver: holding stage, parity source select and output gating.
// It also checks the parity of the raw word received on its source side.
// Assumes: odd_sel_i = 1 selects odd parity.
module pxc_lane
    import parity_xcvr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              le_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              par_i,
    input  logic              odd_sel_i,
    input  par_mode_e         mode_i,
    input  logic              out_en_i,
    output logic [DATA_W-1:0] data_o,
    output logic              par_o,
    output logic              err_n_o
);

    localparam int unsigned WORD_W = DATA_W + 1;

    logic [WORD_W-1:0] held_word;
    logic [DATA_W-1:0] held_data;
    logic              held_par;
    logic              rx_odd;
    logic              held_odd;
    logic              gen_par;
    logic              sel_par;

    // Holding stage for data plus parity
    pxc_hold #(.W(WORD_W)) i_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .le_i  (le_i),
        .d_i   ({data_i, par_i}),
        .q_o   (held_word)
    );

    assign held_data = held_word[WORD_W-1:1];
    assign held_par  = held_word[0];

    // Checker on the raw received word
    pxc_xor_tree #(.W(WORD_W)) i_rx_chk (
        .vec_i (WORD_W'({data_i, par_i})),
        .odd_o (rx_odd)
    );

    // Generator on the held data
    pxc_xor_tree #(.W(DATA_W)) i_tx_gen (
        .vec_i (held_data),
        .odd_o (held_odd)
    );

    // Error flag: low when the received word's ones count disagrees with the sense
    assign err_n_o = ~(rx_odd ^ odd_sel_i);

    // Generated bit completes the word to the selected sense
    assign gen_par = held_odd ^ odd_sel_i;

    // Pick the outgoing parity source
    always_comb begin
        if (mode_i == PAR_PASS) begin
            sel_par = held_par;
        end else begin
            sel_par = gen_par;
        end
    end

    // Outputs read zero when the pad is not driven
    assign data_o = out_en_i ? held_data : '0;
    assign par_o  = out_en_i ? sel_par   : 1'b0;

endmodule

// File: rtl/parity_xcvr.sv
// Two-direction 8-bit transceiver with per-direction holding stages,
// parity generate / pass-through, and parity checking on both sides.
// Assumes: pads are split into input, output and drive-enable ports;
// when both sides request drive, side A wins.
module parity_xcvr
    import parity_xcvr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_data_i,
    input  logic              a_par_i,
    input  logic [DATA_W-1:0] b_data_i,
    input  logic              b_par_i,
    input  logic              le_ab,
    input  logic              le_ba,
    input  logic              odd_sel,
    input  logic              pass_mode,
    input  logic              a_drv_n,
    input  logic              b_drv_n,
    output logic [DATA_W-1:0] a_data_o,
    output logic              a_par_o,
    output logic              a_oe_o,
    output logic [DATA_W-1:0] b_data_o,
    output logic              b_par_o,
    output logic              b_oe_o,
    output logic              a_err_n,
    output logic              b_err_n
);

    // Index 0 = A-to-B, index 1 = B-to-A
    logic [DATA_W-1:0] src_data [NUM_DIR];
    logic              src_par  [NUM_DIR];
    logic              dir_le   [NUM_DIR];
    logic              dst_en   [NUM_DIR];
    logic [DATA_W-1:0] dst_data [NUM_DIR];
    logic              dst_par  [NUM_DIR];
    logic              src_err  [NUM_DIR];
    par_mode_e         mode;

    assign mode = par_mode_e'(pass_mode);

    // Drive arbitration: side A has priority
    assign a_oe_o = ~a_drv_n;
    assign b_oe_o = ~b_drv_n & a_drv_n;

    // Route sides into per-direction arrays
    assign src_data[0] = a_data_i;
    assign src_par[0]  = a_par_i;
    assign dir_le[0]   = le_ab;
    assign dst_en[0]   = b_oe_o;
    assign src_data[1] = b_data_i;
    assign src_par[1]  = b_par_i;
    assign dir_le[1]   = le_ba;
    assign dst_en[1]   = a_oe_o;

    // One lane per direction
    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
        pxc_lane #(.DATA_W(DATA_W)) i_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .le_i      (dir_le[g]),
            .data_i    (src_data[g]),
            .par_i     (src_par[g]),
            .odd_sel_i (odd_sel),
            .mode_i    (mode),
            .out_en_i  (dst_en[g]),
            .data_o    (dst_data[g]),
            .par_o     (dst_par[g]),
            .err_n_o   (src_err[g])
        );
    end

    // Map lanes back onto the side ports
    assign b_data_o = dst_data[0];
    assign b_par_o  = dst_par[0];
    assign a_data_o = dst_data[1];
    assign a_par_o  = dst_par[1];
    assign a_err_n  = src_err[0];
    assign b_err_n  = src_err[1];

endmodule

// File: rtl/parity_xcvr_chk.sv
// Property checker for parity_xcvr, attached by bind.
// Assumes: inputs change away from the rising clock edge.
module parity_xcvr_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] a_data_i,
    input logic              a_par_i,
    input logic [DATA_W-1:0] b_data_i,
    input logic              b_par_i,
    input logic              le_ab,
    input logic              le_ba,
    input logic              odd_sel,
    input logic              pass_mode,
    input logic              a_drv_n,
    input logic              b_drv_n,
    input logic [DATA_W-1:0] a_data_o,
    input logic              a_par_o,
    input logic              a_oe_o,
    input logic [DATA_W-1:0] b_data_o,
    input logic              b_par_o,
    input logic              b_oe_o,
    input logic              a_err_n,
    input logic              b_err_n
);

    assert_transparent_ab_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (le_ab && b_oe_o) |-> (b_data_o == a_data_i));

    assert_transparent_ba_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (le_ba && a_oe_o) |-> (a_data_o == b_data_i));

    assert_hold_ab_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_ab && $past(!le_ab) && $past(rst_n) && b_oe_o && $past(b_oe_o))
            |-> $stable(b_data_o));

    assert_generate_sense_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_mode && b_oe_o) |-> (($countones({b_data_o, b_par_o}) % 2) == int'(odd_sel)));

    assert_pass_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_mode && le_ba && a_oe_o) |-> (a_par_o == b_par_i));

    assert_a_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
        a_err_n == (($countones({a_data_i, a_par_i}) % 2) == int'(odd_sel)));

    assert_b_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        b_err_n == (($countones({b_data_i, b_par_i}) % 2) == int'(odd_sel)));

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !b_oe_o |-> (b_data_o == '0 && !b_par_o));

    assert_single_driver_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_oe_o && b_oe_o));

endmodule

bind parity_xcvr parity_xcvr_chk #(.DATA_W(DATA_W)) i_parity_xcvr_chk (.*);

// File: tb/test_parity_xcvr.sv
module test_parity_xcvr;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] a_data_i, b_data_i;
    logic       a_par_i, b_par_i;
    logic       le_ab, le_ba, odd_sel, pass_mode, a_drv_n, b_drv_n;
    logic [7:0] a_data_o, b_data_o;
    logic       a_par_o, a_oe_o, b_par_o, b_oe_o, a_err_n, b_err_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Bench model of the holding stages: {data, parity}
    logic [8:0] m_ab, m_ba;

    always #10 clk = ~clk;

    parity_xcvr i_parity_xcvr (
        .clk(clk), .rst_n(rst_n),
        .a_data_i(a_data_i), .a_par_i(a_par_i),
        .b_data_i(b_data_i), .b_par_i(b_par_i),
        .le_ab(le_ab), .le_ba(le_ba), .odd_sel(odd_sel), .pass_mode(pass_mode),
        .a_drv_n(a_drv_n), .b_drv_n(b_drv_n),
        .a_data_o(a_data_o), .a_par_o(a_par_o), .a_oe_o(a_oe_o),
        .b_data_o(b_data_o), .b_par_o(b_par_o), .b_oe_o(b_oe_o),
        .a_err_n(a_err_n), .b_err_n(b_err_n)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ab <= '0;
            m_ba <= '0;
        end else begin
            if (le_ab) m_ab <= {a_data_i, a_par_i};
            if (le_ba) m_ba <= {b_data_i, b_par_i};
        end
    end

    typedef struct packed {
        logic       le_ab, le_ba, odd, pass, a_drv_n, b_drv_n;
        logic [7:0] ad;
        logic       ap;
        logic [7:0] bd;
        logic       bp;
        logic       ea_n, eb_n;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h01, 1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h01, 1'b0, 8'hFF, 1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h03, 1'b1, 8'hFF, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h80, 1'b1, 8'h7F, 1'b0, 1'b0, 1'b1},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'hA5, 1'b0, 8'h5A, 1'b0, 1'b1, 1'b1},
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'hFE, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input string what, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic gen_bit(input logic [7:0] d, input logic odd);
        return logic'(($countones(d) % 2) == 1) ^ odd;
    endfunction

    // Compare every output with the bench model
    task automatic check_model(input string req);
        logic       e_aoe, e_boe;
        logic [8:0] wab, wba;
        logic [7:0] e_bd, e_ad;
        logic       e_bp, e_ap;
        e_aoe = !a_drv_n;
        e_boe = !b_drv_n && a_drv_n;
        wab = le_ab ? {a_data_i, a_par_i} : m_ab;
        wba = le_ba ? {b_data_i, b_par_i} : m_ba;
        e_bd = e_boe ? wab[8:1] : 8'h00;
        e_ad = e_aoe ? wba[8:1] : 8'h00;
        e_bp = e_boe ? (pass_mode ? wab[0] : gen_bit(wab[8:1], odd_sel)) : 1'b0;
        e_ap = e_aoe ? (pass_mode ? wba[0] : gen_bit(wba[8:1], odd_sel)) : 1'b0;
        chk(req, "b_data_o", {1'b0, b_data_o}, {1'b0, e_bd});
        chk(req, "a_data_o", {1'b0, a_data_o}, {1'b0, e_ad});
        chk(req, "b_par_o", {8'h0, b_par_o}, {8'h0, e_bp});
        chk(req, "a_par_o", {8'h0, a_par_o}, {8'h0, e_ap});
        chk(req, "oe pair", {7'h0, a_oe_o, b_oe_o}, {7'h0, e_aoe, e_boe});
        chk(req, "a_err_n", {8'h0, a_err_n},
            {8'h0, logic'(($countones({a_data_i, a_par_i}) % 2) == int'(odd_sel))});
        chk(req, "b_err_n", {8'h0, b_err_n},
            {8'h0, logic'(($countones({b_data_i, b_par_i}) % 2) == int'(odd_sel))});
    endtask

    // Drive at the falling edge, sample a quarter period later
    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; le_ab = 1'b0; le_ba = 1'b0; odd_sel = 1'b0; pass_mode = 1'b0;
        a_drv_n = 1'b0; b_drv_n = 1'b1;
        a_data_i = 8'h5C; a_par_i = 1'b1; b_data_i = 8'hE7; b_par_i = 1'b1;
        repeat (3) @(posedge clk);
        settle();
        rst_n = 1'b1;
        #5;
        // R10: held stages cleared, even parity of zero data is 0
        chk("R10", "a_data_o after reset", {1'b0, a_data_o}, 9'h000);
        chk("R10", "a_par_o even after reset", {8'h0, a_par_o}, 9'h000);
        pass_mode = 1'b1;
        #1;
        chk("R10", "held parity after reset", {8'h0, a_par_o}, 9'h000);
        pass_mode = 1'b0; odd_sel = 1'b1;
        #1;
        // R4: odd sense on all-zero data gives parity 1
        chk("R4", "a_par_o odd on zero", {8'h0, a_par_o}, 9'h001);

        // Table walk: transparent paths with hand-computed error flags
        foreach (VECS[i]) begin
            settle();
            {le_ab, le_ba, odd_sel, pass_mode, a_drv_n, b_drv_n} =
                {VECS[i].le_ab, VECS[i].le_ba, VECS[i].odd, VECS[i].pass, VECS[i].a_drv_n, VECS[i].b_drv_n};
            a_data_i = VECS[i].ad; a_par_i = VECS[i].ap;
            b_data_i = VECS[i].bd; b_par_i = VECS[i].bp;
            #5;
            chk("R6", "a_err_n table", {8'h0, a_err_n}, {8'h0, VECS[i].ea_n});
            chk("R7", "b_err_n table", {8'h0, b_err_n}, {8'h0, VECS[i].eb_n});
            if (b_oe_o) chk("R1", "b_data_o transparent", {1'b0, b_data_o}, {1'b0, VECS[i].ad});
            else        chk("R2", "a_data_o transparent", {1'b0, a_data_o}, {1'b0, VECS[i].bd});
            check_model(VECS[i].pass ? "R5" : "R4");
        end

        // R3: capture then close the A-to-B stage and disturb the input
        settle();
        le_ab = 1'b1; a_drv_n = 1'b1; b_drv_n = 1'b0; pass_mode = 1'b1; odd_sel = 1'b0;
        a_data_i = 8'h3C; a_par_i = 1'b1;
        settle();
        le_ab = 1'b0; a_data_i = 8'hC3; a_par_i = 1'b0;
        #5;
        chk("R3", "b_data_o held", {1'b0, b_data_o}, 9'h03C);
        chk("R5", "b_par_o held pass", {8'h0, b_par_o}, 9'h001);
        repeat (2) settle();
        a_data_i = 8'h11;
        #5;
        chk("R3", "b_data_o still held", {1'b0, b_data_o}, 9'h03C);
        // R6: flag follows raw input while stage holds (0x11,0 is even)
        chk("R6", "a_err_n while holding", {8'h0, a_err_n}, 9'h001);
        a_par_i = 1'b1;
        #1;
        chk("R6", "a_err_n bad parity while holding", {8'h0, a_err_n}, 9'h000);

        // R9: both request drive, A wins
        settle();
        a_drv_n = 1'b0; b_drv_n = 1'b0;
        #5;
        chk("R9", "oe with both requests", {7'h0, a_oe_o, b_oe_o}, 9'h002);
        chk("R8", "b_data_o undriven", {1'b0, b_data_o, b_par_o} >> 1, 9'h000);

        // R8: neither requests drive
        settle();
        a_drv_n = 1'b1; b_drv_n = 1'b1;
        #5;
        chk("R8", "oe with no requests", {7'h0, a_oe_o, b_oe_o}, 9'h000);
        chk("R8", "a outputs zero", {a_data_o, a_par_o}, 9'h000);

        // R7: B flag while B-to-A stage holds
        settle();
        le_ba = 1'b0; odd_sel = 1'b1; b_data_i = 8'h07; b_par_i = 1'b0;
        #5;
        chk("R7", "b_err_n odd ok", {8'h0, b_err_n}, 9'h001);

        // Random sweep over all mode, sense, enable and drive combinations
        for (int k = 0; k < 400; k++) begin
            settle();
            {le_ab, le_ba, odd_sel, pass_mode, a_drv_n, b_drv_n} = 6'($urandom);
            a_data_i = 8'($urandom); a_par_i = 1'($urandom);
            b_data_i = 8'($urandom); b_par_i = 1'($urandom);
            #5;
            check_model(pass_mode ? "R5" : "R4");
        end

        // R10: mid-run reset clears captured data
        settle();
        le_ab = 1'b1; a_data_i = 8'hFF; a_par_i = 1'b1; rst_n = 1'b0;
        settle();
        le_ab = 1'b0; rst_n = 1'b1; a_drv_n = 1'b1; b_drv_n = 1'b0; pass_mode = 1'b1;
        #5;
        chk("R10", "b word after reset", {b_data_o, b_par_o}, 9'h000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule